// File: doc/BRIEF.md
# I2C Register-Write Slave Interface

This block is the receive side of an I2C target that accepts 16-bit register writes. It oversamples the SCL and SDA lines with a fast system clock and finds START, repeated START and STOP conditions. It then checks the 7-bit target address. After a matching address with a write direction bit, it takes a command byte. The top bit of the command byte is a register-level direction flag. The low seven bits name the register. A fixed pair of data bytes follows, and the block assembles them into one register word. It presents the register address, the word and a single-cycle write strobe to the register file behind it.

The block also tracks the high-speed bus state. A master code after a START puts the bus into high-speed mode. A STOP takes it back to standard/fast mode, and a repeated START leaves the mode as it is. SDA is driven only through an open-drain enable: when the enable is 1, the pad pulls the line low. Read data return, clock stretching and pad timing are not part of this block.

Top module: `i2c_regwr_slave`

## Requirements
- R1: After reset, `sda_oe_o`, `reg_wr_o` and `hs_mode_o` are 0, and `reg_addr_o` and `reg_data_o` are all zeros.
- R2: After a START, an address byte whose upper 7 bits equal `SLAVE_ADDR` and whose bit 0 (the bus direction bit) is 0 is acknowledged. The block sets `sda_oe_o` to 1 for the ninth SCL clock of that byte.
- R3: An address byte that does not match, or that matches with bit 0 = 1, is not acknowledged. No later byte is acknowledged until the next START or STOP, and no strobe is issued.
- R4: The byte after a matched address is the command byte, and it is acknowledged. When its bit 7 is 0, its bits 6..0 become the register address of the write.
- R5: Both data bytes are acknowledged. The first data byte becomes bits 15..8 of the word and the second becomes bits 7..0. `reg_wr_o` is high for exactly one system clock, after the acknowledge clock of the second data byte. `reg_addr_o` and `reg_data_o` take their new values in that same cycle and do not change at any other time.
- R6: When bit 7 of the command byte is 1, the data bytes are still acknowledged, but no strobe is issued and `reg_addr_o`/`reg_data_o` keep their values.
- R7: Bytes after the second data byte are not acknowledged and cause no further strobe.
- R8: A repeated START ends the current transaction like a STOP. The block releases SDA, and the address that follows starts a new transaction.
- R9: An address-phase byte of the form 00001xxx is a master code. It is not acknowledged, and it sets `hs_mode_o` to 1.
- R10: A STOP clears `hs_mode_o`. A repeated START leaves `hs_mode_o` unchanged.
- R11: A START or STOP that arrives in the middle of a byte aborts the transaction. No strobe is issued, and the next transaction is received normally.
- R12: `sda_oe_o` changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level from the pad |
| sda_i | input | 1 | SDA line level from the pad (wired bus value) |
| sda_oe_o | output | 1 | Pull SDA low when 1 (acknowledge) |
| reg_addr_o | output | 7 | Register address of the last write |
| reg_data_o | output | 16 | Register word of the last write |
| reg_wr_o | output | 1 | One-cycle register write strobe |
| hs_mode_o | output | 1 | High-speed bus mode active |

## Verification
Some properties are checked by the assertions on every cycle. The write strobe is never longer than one cycle, and the register outputs never move without it. A STOP event always clears the high-speed flag and a START event always releases SDA. The SDA enable only changes while SCL is low. The bench scenarios are the only place the byte-level decisions can be seen. These are which bytes get an acknowledge, the order in which the two data bytes fill the word, the suppressed write when the command flag is set, the rejection of a wrong address or a read direction, the handling of surplus bytes, and recovery after an abort in the middle of a byte.

// File: rtl/i2c_rw_pkg.sv
package i2c_rw_pkg;

  // Transaction phase of the receiver
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_DATA,
    ST_SKIP
  } rw_state_e;

  localparam int BYTE_W = 8;
  localparam logic [4:0] MCODE_PREFIX = 5'b00001;

endpackage

// File: rtl/i2c_rw_sync.sv
module i2c_rw_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d_i[g]};
      end
      assign q_o[g] = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/i2c_rw_events.sv
module i2c_rw_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic ev_start,
  output logic ev_stop,
  output logic scl_rise,
  output logic scl_fall
);

  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  // Data line moving while the clock line stays high marks a bus condition
  assign ev_start = scl_s & scl_q & sda_q & ~sda_s;
  assign ev_stop  = scl_s & scl_q & ~sda_q & sda_s;
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;

endmodule

// File: rtl/i2c_rw_core.sv
module i2c_rw_core
  import i2c_rw_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h3A,
  parameter int         RADDR_W    = 7,
  parameter int         DATA_BYTES = 2,
  localparam int        DATA_W     = BYTE_W * DATA_BYTES
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sda_s,
  input  logic               ev_start,
  input  logic               ev_stop,
  input  logic               scl_rise,
  input  logic               scl_fall,
  output logic               sda_oe,
  output logic [RADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0]  reg_data,
  output logic               reg_wr,
  output logic               hs_mode
);

  localparam int IDX_W = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_BYTES - 1);

  rw_state_e            state;
  rw_state_e            nxt_state;
  logic                 in_ack;
  logic [3:0]           bit_cnt;
  logic [BYTE_W-1:0]    shreg;
  logic                 cmd_wr;
  logic [RADDR_W-1:0]   cmd_addr;
  logic [DATA_W-1:0]    data_sr;
  logic [IDX_W-1:0]     data_idx;
  logic                 pend_wr;
  logic                 ack_now;
  logic                 is_mcode;
  logic                 byte_done;
  logic                 ack_done;

  assign is_mcode  = (shreg[7:3] == MCODE_PREFIX);
  assign byte_done = scl_fall && !in_ack && (bit_cnt == 4'd8);
  assign ack_done  = scl_fall && in_ack;

  // Acknowledge decision and next phase for the byte just received
  always_comb begin
    ack_now   = 1'b0;
    nxt_state = state;
    unique case (state)
      ST_ADDR: begin
        if (!is_mcode && shreg[7:1] == SLAVE_ADDR && !shreg[0]) begin
          ack_now   = 1'b1;
          nxt_state = ST_CMD;
        end else begin
          nxt_state = ST_SKIP;
        end
      end
      ST_CMD: begin
        ack_now   = 1'b1;
        nxt_state = ST_DATA;
      end
      ST_DATA: begin
        ack_now   = 1'b1;
        nxt_state = (data_idx == LAST_IDX) ? ST_SKIP : ST_DATA;
      end
      default: begin
        ack_now   = 1'b0;
        nxt_state = state;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      in_ack   <= 1'b0;
      bit_cnt  <= '0;
      shreg    <= '0;
      sda_oe   <= 1'b0;
      cmd_wr   <= 1'b0;
      cmd_addr <= '0;
      data_sr  <= '0;
      data_idx <= '0;
      pend_wr  <= 1'b0;
      hs_mode  <= 1'b0;
      reg_wr   <= 1'b0;
      reg_addr <= '0;
      reg_data <= '0;
    end else begin
      reg_wr <= 1'b0;
      if (ev_start) begin
        state   <= ST_ADDR;
        in_ack  <= 1'b0;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
        pend_wr <= 1'b0;
      end else if (ev_stop) begin
        state   <= ST_IDLE;
        in_ack  <= 1'b0;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
        pend_wr <= 1'b0;
        hs_mode <= 1'b0;
      end else if (state != ST_IDLE) begin
        if (scl_rise && !in_ack && bit_cnt < 4'd8) begin
          shreg   <= {shreg[BYTE_W-2:0], sda_s};
          bit_cnt <= bit_cnt + 4'd1;
        end else if (byte_done) begin
          in_ack <= 1'b1;
          sda_oe <= ack_now;
          state  <= nxt_state;
          unique case (state)
            ST_ADDR: begin
              if (is_mcode) hs_mode <= 1'b1;
            end
            ST_CMD: begin
              cmd_wr   <= ~shreg[7];
              cmd_addr <= shreg[RADDR_W-1:0];
              data_idx <= '0;
            end
            ST_DATA: begin
              data_sr <= (data_sr << BYTE_W) | {{(DATA_W-BYTE_W){1'b0}}, shreg};
              if (data_idx == LAST_IDX) pend_wr  <= cmd_wr;
              else                      data_idx <= data_idx + 1'b1;
            end
            default: ;
          endcase
        end else if (ack_done) begin
          in_ack  <= 1'b0;
          bit_cnt <= '0;
          sda_oe  <= 1'b0;
          if (pend_wr) begin
            pend_wr  <= 1'b0;
            reg_wr   <= 1'b1;
            reg_addr <= cmd_addr;
            reg_data <= data_sr;
          end
        end
      end
    end
  end

endmodule

// File: rtl/i2c_regwr_slave.sv
module i2c_regwr_slave #(
  parameter logic [6:0] SLAVE_ADDR  = 7'h3A,
  parameter int         SYNC_STAGES = 2,
  parameter int         RADDR_W     = 7,
  parameter int         DATA_BYTES  = 2,
  localparam int        DATA_W      = 8 * DATA_BYTES
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  output logic [RADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0]  reg_data_o,
  output logic               reg_wr_o,
  output logic               hs_mode_o
);

  logic [1:0] line_s;
  logic       scl_s;
  logic       sda_s;
  logic       ev_start;
  logic       ev_stop;
  logic       scl_rise;
  logic       scl_fall;

  i2c_rw_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst (rst),
    .d_i ({scl_i, sda_i}),
    .q_o (line_s)
  );

  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  i2c_rw_events events_i (
    .clk      (clk),
    .rst      (rst),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .ev_start (ev_start),
    .ev_stop  (ev_stop),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall)
  );

  i2c_rw_core #(
    .SLAVE_ADDR (SLAVE_ADDR),
    .RADDR_W    (RADDR_W),
    .DATA_BYTES (DATA_BYTES)
  ) core_i (
    .clk      (clk),
    .rst      (rst),
    .sda_s    (sda_s),
    .ev_start (ev_start),
    .ev_stop  (ev_stop),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .sda_oe   (sda_oe_o),
    .reg_addr (reg_addr_o),
    .reg_data (reg_data_o),
    .reg_wr   (reg_wr_o),
    .hs_mode  (hs_mode_o)
  );

endmodule

// File: rtl/i2c_regwr_slave_chk.sv
module i2c_regwr_slave_chk #(
  parameter int RADDR_W = 7,
  parameter int DATA_W  = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               scl_s,
  input logic               ev_start,
  input logic               ev_stop,
  input logic               sda_oe_o,
  input logic [RADDR_W-1:0] reg_addr_o,
  input logic [DATA_W-1:0]  reg_data_o,
  input logic               reg_wr_o,
  input logic               hs_mode_o
);

  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (rst)
    reg_wr_o |=> !reg_wr_o);

  assert_outputs_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !reg_wr_o |-> ($stable(reg_data_o) && $stable(reg_addr_o)));

  assert_stop_clears_hs_R10: assert property (@(posedge clk) disable iff (rst)
    ev_stop |=> !hs_mode_o);

  assert_start_releases_R8: assert property (@(posedge clk) disable iff (rst)
    ev_start |=> !sda_oe_o);

  assert_drive_scl_low_R12: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe_o) |-> !scl_s);

endmodule

bind i2c_regwr_slave i2c_regwr_slave_chk #(
  .RADDR_W (RADDR_W),
  .DATA_W  (DATA_W)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .scl_s      (scl_s),
  .ev_start   (ev_start),
  .ev_stop    (ev_stop),
  .sda_oe_o   (sda_oe_o),
  .reg_addr_o (reg_addr_o),
  .reg_data_o (reg_data_o),
  .reg_wr_o   (reg_wr_o),
  .hs_mode_o  (hs_mode_o)
);

// File: tb/i2c_regwr_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_regwr_slave_tb_top;

  localparam logic [6:0] SADDR = 7'h3A;
  localparam int Q = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_oe_o;
  logic [6:0]  reg_addr_o;
  logic [15:0] reg_data_o;
  logic        reg_wr_o;
  logic        hs_mode_o;
  logic        sda_bus;

  int checks = 0;
  int errors = 0;
  int wr_cnt = 0;
  logic ack_seen;

  always #4 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe_o;

  i2c_regwr_slave #(.SLAVE_ADDR(SADDR)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl_m),
    .sda_i      (sda_bus),
    .sda_oe_o   (sda_oe_o),
    .reg_addr_o (reg_addr_o),
    .reg_data_o (reg_data_o),
    .reg_wr_o   (reg_wr_o),
    .hs_mode_o  (hs_mode_o)
  );

  always @(negedge clk) if (!rst && reg_wr_o) wr_cnt++;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq();
    wq();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wq();
      scl_m = 1'b1; wq(); wq();
      scl_m = 1'b0; wq();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    @(negedge clk);
    ack = ~sda_bus;
    wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic t_reset();
    chk(sda_oe_o == 1'b0, "R1", "sda_oe after reset", sda_oe_o, 0);
    chk(reg_wr_o == 1'b0, "R1", "reg_wr after reset", reg_wr_o, 0);
    chk(hs_mode_o == 1'b0, "R1", "hs_mode after reset", hs_mode_o, 0);
    chk(reg_data_o == 16'h0 && reg_addr_o == 7'h0, "R1", "outputs after reset",
        {reg_addr_o, reg_data_o}, 0);
  endtask

  task automatic t_basic_write();
    int c0 = wr_cnt;
    bus_start();
    send_byte({SADDR, 1'b0}, ack_seen);
    chk(ack_seen, "R2", "address ack", ack_seen, 1);
    send_byte(8'h15, ack_seen);
    chk(ack_seen, "R4", "command ack", ack_seen, 1);
    send_byte(8'hA5, ack_seen);
    chk(ack_seen, "R5", "data hi ack", ack_seen, 1);
    send_byte(8'h5A, ack_seen);
    chk(ack_seen, "R5", "data lo ack", ack_seen, 1);
    bus_stop();
    chk(wr_cnt == c0 + 1, "R5", "strobe count", wr_cnt - c0, 1);
    chk(reg_addr_o == 7'h15, "R4", "register address", reg_addr_o, 7'h15);
    chk(reg_data_o == 16'hA55A, "R5", "register word order", reg_data_o, 16'hA55A);
  endtask

  task automatic t_extra_byte();
    int c0 = wr_cnt;
    bus_start();
    send_byte({SADDR, 1'b0}, ack_seen);
    send_byte(8'h22, ack_seen);
    send_byte(8'h12, ack_seen);
    send_byte(8'h34, ack_seen);
    send_byte(8'h99, ack_seen);
    chk(!ack_seen, "R7", "surplus byte not acked", ack_seen, 0);
    bus_stop();
    chk(wr_cnt == c0 + 1, "R7", "one strobe only", wr_cnt - c0, 1);
    chk(reg_data_o == 16'h1234 && reg_addr_o == 7'h22, "R7", "word after surplus",
        reg_data_o, 16'h1234);
  endtask

  task automatic t_bad_addr();
    int c0 = wr_cnt;
    bus_start();
    send_byte({SADDR ^ 7'h01, 1'b0}, ack_seen);
    chk(!ack_seen, "R3", "wrong address not acked", ack_seen, 0);
    send_byte(8'h10, ack_seen);
    chk(!ack_seen, "R3", "byte after wrong address", ack_seen, 0);
    send_byte(8'hEE, ack_seen);
    send_byte(8'hFF, ack_seen);
    bus_stop();
    bus_start();
    send_byte({SADDR, 1'b1}, ack_seen);
    chk(!ack_seen, "R3", "read direction not acked", ack_seen, 0);
    bus_stop();
    chk(wr_cnt == c0, "R3", "no strobe", wr_cnt - c0, 0);
    chk(reg_data_o == 16'h1234, "R3", "word unchanged", reg_data_o, 16'h1234);
  endtask

  task automatic t_cmd_read_flag();
    int c0 = wr_cnt;
    bus_start();
    send_byte({SADDR, 1'b0}, ack_seen);
    send_byte(8'h85, ack_seen);
    chk(ack_seen, "R6", "flagged command ack", ack_seen, 1);
    send_byte(8'hDE, ack_seen);
    send_byte(8'hAD, ack_seen);
    chk(ack_seen, "R6", "data still acked", ack_seen, 1);
    bus_stop();
    chk(wr_cnt == c0, "R6", "no strobe", wr_cnt - c0, 0);
    chk(reg_data_o == 16'h1234 && reg_addr_o == 7'h22, "R6", "outputs unchanged",
        reg_data_o, 16'h1234);
  endtask

  task automatic t_rstart_chain();
    int c0 = wr_cnt;
    bus_start();
    send_byte({SADDR, 1'b0}, ack_seen);
    send_byte(8'h01, ack_seen);
    send_byte(8'h11, ack_seen);
    send_byte(8'h22, ack_seen);
    bus_rstart();
    chk(sda_oe_o == 1'b0, "R8", "released after Sr", sda_oe_o, 0);
    send_byte({SADDR, 1'b0}, ack_seen);
    chk(ack_seen, "R8", "address after Sr acked", ack_seen, 1);
    send_byte(8'h02, ack_seen);
    send_byte(8'h33, ack_seen);
    send_byte(8'h44, ack_seen);
    bus_stop();
    chk(wr_cnt == c0 + 2, "R8", "two strobes", wr_cnt - c0, 2);
    chk(reg_data_o == 16'h3344 && reg_addr_o == 7'h02, "R8", "second write",
        reg_data_o, 16'h3344);
  endtask

  task automatic t_hs_mode();
    int c0 = wr_cnt;
    bus_start();
    send_byte(8'h0B, ack_seen);
    chk(!ack_seen, "R9", "master code not acked", ack_seen, 0);
    chk(hs_mode_o == 1'b1, "R9", "hs mode set", hs_mode_o, 1);
    bus_rstart();
    send_byte({SADDR, 1'b0}, ack_seen);
    send_byte(8'h07, ack_seen);
    send_byte(8'hBE, ack_seen);
    send_byte(8'hEF, ack_seen);
    bus_rstart();
    chk(hs_mode_o == 1'b1, "R10", "hs kept over Sr", hs_mode_o, 1);
    bus_stop();
    chk(hs_mode_o == 1'b0, "R10", "hs cleared by stop", hs_mode_o, 0);
    chk(wr_cnt == c0 + 1 && reg_data_o == 16'hBEEF, "R9", "write in hs mode",
        reg_data_o, 16'hBEEF);
  endtask

  task automatic t_abort();
    int c0 = wr_cnt;
    bus_start();
    send_byte({SADDR, 1'b0}, ack_seen);
    send_byte(8'h09, ack_seen);
    send_byte(8'h55, ack_seen);
    send_bits(8'h66, 4);
    bus_stop();
    chk(wr_cnt == c0, "R11", "stop mid-byte no strobe", wr_cnt - c0, 0);
    bus_start();
    send_byte({SADDR, 1'b0}, ack_seen);
    send_byte(8'h09, ack_seen);
    send_bits(8'h77, 3);
    bus_rstart();
    send_byte({SADDR, 1'b0}, ack_seen);
    chk(ack_seen, "R11", "address after abort acked", ack_seen, 1);
    send_byte(8'h0C, ack_seen);
    send_byte(8'hC0, ack_seen);
    send_byte(8'hDE, ack_seen);
    bus_stop();
    chk(wr_cnt == c0 + 1, "R11", "one strobe after aborts", wr_cnt - c0, 1);
    chk(reg_data_o == 16'hC0DE && reg_addr_o == 7'h0C, "R11", "recovered write",
        reg_data_o, 16'hC0DE);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    repeat (5) @(posedge clk);
    #1;
    t_reset();
    t_basic_write();
    t_extra_byte();
    t_bad_addr();
    t_cmd_read_flag();
    t_rstart_chain();
    t_hs_mode();
    t_abort();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule